// File: doc/BRIEF.md
# Bit-Selectable Charge-Time Terminator

This block times the charge phase of a capacitor-discharge resistance reader. A one-clock start pulse clears an internal 12-bit up-counter and raises the charge-active output. The counter advances once per clock while charging. The phase ends on the first count at which a chosen counter bit is 1, or at which a chosen pair of adjacent bits are both 1. At that moment the counter freezes, charge-active falls, and a one-clock done pulse tells the following stage that discharge may begin.

Testing one or two counter bits takes the place of a full-width terminal-count comparator. A 3-bit select code picks one of seven durations, from 96 clocks to 2048 clocks. With a 20 ns clock these are 1.92 µs and 40.96 µs. The block does not choose which discharge follows.

Top module: `charge_term`

## Requirements
- R1: While rst_ni is low, and after it is released, charging_o and done_o are 0 until a start is accepted.
- R2: A start_i pulse while idle clears the counter, and charging_o is 1 from the next cycle on.
- R3: charging_o stays high for exactly K cycles, where K depends on sel_i: code 0 (bits 6 and 5) gives 96, code 1 (bit 7) gives 128, code 2 (bits 7 and 6) gives 192, code 3 (bit 8) gives 256, code 4 (bit 9) gives 512, code 5 (bit 10) gives 1024, and code 6 (bit 11) gives 2048.
- R4: done_o is high for exactly one cycle. It is high in the first cycle in which charging_o is low after a charge, and charging_o is never high together with done_o.
- R5: A start_i pulse that arrives while charging_o is high has no effect on the charge length.
- R6: sel_i is captured when start is accepted, so a change of sel_i during a charge does not change that charge's length.
- R7: Code 7 behaves as code 6 (2048 cycles).
- R8: A start_i pulse in the cycle where done_o is high is accepted and begins a new full-length charge.
- R9: The counter advances by one on each charging cycle and holds its value while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Charge start pulse |
| sel_i | input | 3 | Duration select code |
| charging_o | output | 1 | Charge phase active |
| done_o | output | 1 | One-clock end-of-charge pulse |

## Verification
The bench runs every select code to completion and counts the high cycles of charging_o against the table in R3. An off-by-one in the stop compare would show up as 95 or 97 cycles. A bad bit-pair decode would give a length such as 32 or 64 instead of 96. Mid-charge start pulses and mid-charge select changes are injected. A design that restarted on such a pulse would stretch the charge, and one that read sel_i live would cut it short. A restart in the done cycle is also tried, because a design that gates start on done would drop that start and stay idle.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned NUM_CODES = 1 << SEL_W;

  typedef logic [SEL_W-1:0] sel_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_CHARGE = 1'b1
  } ct_state_e;
endpackage

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_inc_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_inc_o = cnt_q + CNT_W'(1);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_inc_o;
  end
endmodule

// File: rtl/ct_match.sv
module ct_match
  import ct_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  sel_t             sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o
);
  // Stop mask for each select code, anchored to the counter MSB.
  function automatic logic [CNT_W-1:0] code_mask(int unsigned c);
    logic [CNT_W-1:0] m;
    m = '0;
    case (c)
      0: begin m[CNT_W-6] = 1'b1; m[CNT_W-7] = 1'b1; end
      1: m[CNT_W-5] = 1'b1;
      2: begin m[CNT_W-5] = 1'b1; m[CNT_W-6] = 1'b1; end
      3: m[CNT_W-4] = 1'b1;
      4: m[CNT_W-3] = 1'b1;
      5: m[CNT_W-2] = 1'b1;
      default: m[CNT_W-1] = 1'b1;
    endcase
    return m;
  endfunction

  logic [CNT_W-1:0] mask_tab [NUM_CODES];
  logic [NUM_CODES-1:0] code_hit;

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    assign mask_tab[c] = code_mask(c);
    assign code_hit[c] = ((cnt_i & mask_tab[c]) == mask_tab[c]);
  end

  assign hit_o = code_hit[sel_i];
endmodule

// File: rtl/charge_term.sv
module charge_term
  import ct_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] sel_i,
  output logic       charging_o,
  output logic       done_o
);
  ct_state_e        state_q;
  sel_t             sel_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             start_acc;
  logic             stop_hit;
  logic             charging;

  assign charging  = (state_q == ST_CHARGE);
  assign start_acc = start_i && !charging;

  ct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_acc),
    .en_i      (charging),
    .cnt_o     (cnt_q),
    .cnt_inc_o (cnt_inc)
  );

  // Look at the next count so charge ends on the matching count, not one later.
  ct_match #(.CNT_W(CNT_W)) u_match (
    .sel_i (sel_q),
    .cnt_i (cnt_inc),
    .hit_o (stop_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CHARGE;
          sel_q   <= sel_i;
        end
        ST_CHARGE: if (stop_hit) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign charging_o = charging;
  assign done_o     = done_q;
endmodule

// File: rtl/charge_term_chk.sv
module charge_term_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             charging_o,
  input logic             done_o,
  input logic [CNT_W-1:0] cnt_i
);
  // R4
  done_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !charging_o);
  // R4
  fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(charging_o) |-> done_o);
  // R2
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !charging_o) |=> (charging_o && cnt_i == '0));
  // R9
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    charging_o |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));
  // R9
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!charging_o && !start_i) |=> $stable(cnt_i));
endmodule

bind charge_term charge_term_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .charging_o (charging_o),
  .done_o     (done_o),
  .cnt_i      (cnt_q)
);

// File: tb/sim_charge_term.sv
module sim_charge_term;
  localparam int CLK_PERIOD = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [2:0] sel_i;
  logic       charging_o;
  logic       done_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  charge_term u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sel_i      (sel_i),
    .charging_o (charging_o),
    .done_o     (done_o)
  );

  function automatic int exp_len(int code);
    case (code)
      0: return 96;
      1: return 128;
      2: return 192;
      3: return 256;
      4: return 512;
      5: return 1024;
      default: return 2048;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference: one flag, a count and a target.
  bit m_chg, m_done;
  int m_n, m_k;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_chg = 0; m_done = 0; m_n = 0; m_k = 0;
    end else begin
      m_done = 0;
      if (m_chg) begin
        m_n++;
        if (m_n == m_k) begin m_chg = 0; m_done = 1; end
      end else if (start_i) begin
        m_chg = 1; m_n = 0; m_k = exp_len(int'(sel_i));
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      check("R2 R4 model charging", int'(charging_o), int'(m_chg));
      check("R4 model done", int'(done_o), int'(m_done));
    end
  end

  // Pulse start (optionally right away), then count charging cycles until done.
  task automatic run_charge(input int code, input bit now, input bit mid_start,
                            input bit mid_sel, output int len);
    int guard;
    if (!now) @(negedge clk_i);
    sel_i = 3'(code);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    len = 0;
    guard = 0;
    while (!done_o && guard < 5000) begin
      if (charging_o) len++;
      start_i = (mid_start && len == 30);
      if (mid_sel && len == 30) sel_i = 3'd0;
      guard++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  int len;

  initial begin
    rst_ni  = 1'b0;
    start_i = 1'b0;
    sel_i   = 3'd0;
    repeat (3) @(negedge clk_i);
    check("R1 reset charging", int'(charging_o), 0);
    check("R1 reset done", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 idle charging", int'(charging_o), 0);
    check("R1 idle done", int'(done_o), 0);

    for (int c = 0; c < 7; c++) begin
      run_charge(c, 1'b0, 1'b0, 1'b0, len);
      check($sformatf("R3 length code %0d", c), len, exp_len(c));
      check("R4 charging low at done", int'(charging_o), 0);
      @(negedge clk_i);
      check("R4 done one cycle", int'(done_o), 0);
    end

    run_charge(7, 1'b0, 1'b0, 1'b0, len);
    check("R7 code 7 length", len, 2048);

    run_charge(1, 1'b0, 1'b1, 1'b0, len);
    check("R5 mid start ignored", len, 128);

    run_charge(4, 1'b0, 1'b0, 1'b1, len);
    check("R6 select held", len, 512);

    run_charge(0, 1'b0, 1'b0, 1'b0, len);
    check("R8 first of pair", len, 96);
    run_charge(2, 1'b1, 1'b0, 1'b0, len);
    check("R8 restart on done", len, 192);

    repeat (5) @(negedge clk_i);
    check("R9 stays idle", int'(charging_o), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule